// File: doc/BRIEF.md
# Glitch-Free Differential Clock Output Stop Controller

This block drives a small group of differential clock output channels. Each channel has a true leg and a complement leg, and each leg has its own level and three-state enable. The output timing comes from the block clock `clk`. Each output half-period lasts `HALF_CYCLES` clock cycles, so one output period is `2*HALF_CYCLES` cycles. The true leg rises on a "true-rise edge", and the complement leg rises on a "complement-rise edge" half a period later.

Two asynchronous active-low requests control the channels: a stop request and a power-down request. Each channel also has an enable pin and a register enable bit. Each request passes through a two-flop synchroniser. It is then accepted only when two consecutive complement-rise samples agree.

Configuration bits from a register file choose, for each channel, whether it follows the stop request. They also choose whether stopping and powering down park the legs at fixed levels or three-state them. A channel changes state only at a true-rise edge, so it never emits a shortened pulse.

Top module: `diff_clk_stop`

## Requirements
- R1: A change of `stopN` is accepted only once two consecutive complement-rise samples of the synchronised value agree. A low pulse shorter than one output period never stops any channel.
- R2: `pdN` is debounced in the same way. Power-down affects every enabled channel, including free-running ones, and it takes priority over the stop request. A short low glitch on `pdN` has no effect.
- R3: While stopped with `stopDriveZ`=0, a channel drives true=1 and complement=0. With `stopDriveZ`=1 both legs are three-stated.
- R4: While powered down with `pdDriveZ`=0, the true leg is driven at 1 and the complement leg is three-stated. With `pdDriveZ`=1 both legs are three-stated. The complement leg is never driven while the true leg is three-stated.
- R5: A channel whose `cfgStoppable` bit is 0 keeps running while the stop request is active. Channels whose bit is 1 stop.
- R6: A channel is three-stated when its `cfgEnable` bit is 0, or when its pin is honoured and low. This condition overrides both the stop and power-down modes. Only the channels set in `PIN_MASK` (default 4'b1001: channels 0 and 3) honour `enPin`; the other channels ignore it.
- R7: After the stop request is released, all stopped channels resume on the same clock edge, within six output periods.
- R8: A change of an enable pin takes effect within six output periods.
- R9: Mode changes occur only at true-rise edges. No driven leg ever holds a level for fewer than `HALF_CYCLES` cycles between two level changes. A leg that starts being driven starts with true=1 and complement=0.
- R10: During reset, all legs are three-stated and all levels are 0.
- R11: When both legs of a channel are driven, they are opposite. A leg that is not driven shows level 0.
- R12: A running channel's true leg has a period of `2*HALF_CYCLES` cycles and stays high for `HALF_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; one output half-period spans HALF_CYCLES cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| stopN | input | 1 | Asynchronous active-low stop request |
| pdN | input | 1 | Asynchronous active-low power-down request |
| enPin | input | NUM_CH | Asynchronous per-channel enable pins, active high |
| cfgEnable | input | NUM_CH | Register enable bit per channel |
| cfgStoppable | input | NUM_CH | 1 = channel follows the stop request |
| stopDriveZ | input | 1 | Stop drive mode: 0 = park driven, 1 = three-state |
| pdDriveZ | input | 1 | Power-down drive mode: 0 = true high and complement floating, 1 = three-state |
| trueOut | output | NUM_CH | True leg level per channel |
| compOut | output | NUM_CH | Complement leg level per channel |
| trueOe | output | NUM_CH | True leg drive enable per channel |
| compOe | output | NUM_CH | Complement leg drive enable per channel |

## Verification
The assertions watch every channel on every cycle. They check the leg relations: opposite levels when both legs are driven, level 0 when a leg is undriven, and the complement never driven alone. They also check that the power-down park shape has the true leg high, that no driven leg shows a runt pulse, and that driving always begins with the true leg high. Only the bench scenarios can show the time-based behaviour: that a short request pulse is rejected, that power-down wins over stop, and which channels stop for each stoppable mask. The bench also sweeps the full enable bit and pin matrix, and measures the resume and enable latencies.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Per-channel output state; changes only at a true-rise edge.
  typedef enum logic [1:0] {
    CH_RUN  = 2'd0,   // both legs toggle
    CH_PARK = 2'd1,   // true 1, comp 0, both driven
    CH_PDHI = 2'd2,   // true 1 driven, comp floating
    CH_OFF  = 2'd3    // both legs floating
  } chMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic trueRise;   // this edge makes the true leg rise
    logic levelNext;  // running true level after this edge
    logic stopReq;    // debounced stop request, active high
    logic pdReq;      // debounced power-down request, active high
  } stopStrb_t;

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= {STAGES{RST_VAL}};
    else       stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int HALF_CYCLES = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_CH-1:0] PIN_MASK = NUM_CH'(9)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopN,
  input  logic              pdN,
  input  logic [NUM_CH-1:0] enPin,
  output stopStrb_t         strb,
  output logic [NUM_CH-1:0] pinGate
);
  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYCLES - 1);
  localparam int NUM_REQ = 2;  // index 0 stop, index 1 power-down

  logic [CNT_W-1:0] halfCnt;
  logic             phase;
  logic             halfEnd;
  logic             compRise;
  logic [NUM_REQ-1:0] reqSync, reqLast, reqAcc;
  logic [NUM_CH-1:0]  pinSync;

  // Output phase generator
  assign halfEnd  = (halfCnt == CNT_LAST);
  assign compRise = halfEnd & phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      phase   <= 1'b0;
    end else if (halfEnd) begin
      halfCnt <= '0;
      phase   <= ~phase;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  // Synchronisers
  clkstop_sync #(.W(NUM_REQ), .STAGES(SYNC_STAGES), .RST_VAL({NUM_REQ{1'b1}})) u_reqSync (
    .clk(clk), .rstN(rstN), .d({pdN, stopN}), .q(reqSync)
  );

  clkstop_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pinSync (
    .clk(clk), .rstN(rstN), .d(enPin), .q(pinSync)
  );

  // Two-sample debounce on complement-rise edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqLast <= '1;
      reqAcc  <= '1;
    end else if (compRise) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        reqLast[r] <= reqSync[r];
        if (reqSync[r] == reqLast[r]) reqAcc[r] <= reqSync[r];
      end
    end
  end

  // Channels outside the pin mask see a permanently high pin
  assign pinGate = pinSync | ~PIN_MASK;

  always_comb begin
    strb.trueRise  = halfEnd & ~phase;
    strb.levelNext = halfEnd ? ~phase : phase;
    strb.stopReq   = ~reqAcc[0];
    strb.pdReq     = ~reqAcc[1];
  end
endmodule

// File: rtl/clkstop_dp.sv
module clkstop_dp
  import clkstop_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  stopStrb_t         strb,
  input  logic [NUM_CH-1:0] pinGate,
  input  logic [NUM_CH-1:0] cfgEnable,
  input  logic [NUM_CH-1:0] cfgStoppable,
  input  logic              stopDriveZ,
  input  logic              pdDriveZ,
  output logic [NUM_CH-1:0] trueOut,
  output logic [NUM_CH-1:0] compOut,
  output logic [NUM_CH-1:0] trueOe,
  output logic [NUM_CH-1:0] compOe
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chMode_e modeQ, modeD, tgt;
    logic    chEn;
    logic    tN, cN, toN, coN;
    logic    tQ, cQ, toQ, coQ;

    assign chEn = cfgEnable[c] & pinGate[c];

    // Priority: disable, power-down, stop, run
    always_comb begin
      if (!chEn)                              tgt = CH_OFF;
      else if (strb.pdReq)                    tgt = pdDriveZ ? CH_OFF : CH_PDHI;
      else if (strb.stopReq && cfgStoppable[c]) tgt = stopDriveZ ? CH_OFF : CH_PARK;
      else                                    tgt = CH_RUN;
    end

    assign modeD = strb.trueRise ? tgt : modeQ;

    always_comb begin
      unique case (modeD)
        CH_RUN:  begin tN = strb.levelNext; cN = ~strb.levelNext; toN = 1'b1; coN = 1'b1; end
        CH_PARK: begin tN = 1'b1; cN = 1'b0; toN = 1'b1; coN = 1'b1; end
        CH_PDHI: begin tN = 1'b1; cN = 1'b0; toN = 1'b1; coN = 1'b0; end
        CH_OFF:  begin tN = 1'b0; cN = 1'b0; toN = 1'b0; coN = 1'b0; end
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ <= CH_OFF;
        tQ    <= 1'b0;
        cQ    <= 1'b0;
        toQ   <= 1'b0;
        coQ   <= 1'b0;
      end else begin
        modeQ <= modeD;
        tQ    <= tN;
        cQ    <= cN;
        toQ   <= toN;
        coQ   <= coN;
      end
    end

    assign trueOut[c] = tQ;
    assign compOut[c] = cQ;
    assign trueOe[c]  = toQ;
    assign compOe[c]  = coQ;
  end
endmodule

// File: rtl/diff_clk_stop.sv
module diff_clk_stop
  import clkstop_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int HALF_CYCLES = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_CH-1:0] PIN_MASK = NUM_CH'(9)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopN,
  input  logic              pdN,
  input  logic [NUM_CH-1:0] enPin,
  input  logic [NUM_CH-1:0] cfgEnable,
  input  logic [NUM_CH-1:0] cfgStoppable,
  input  logic              stopDriveZ,
  input  logic              pdDriveZ,
  output logic [NUM_CH-1:0] trueOut,
  output logic [NUM_CH-1:0] compOut,
  output logic [NUM_CH-1:0] trueOe,
  output logic [NUM_CH-1:0] compOe
);
  stopStrb_t         strb;
  logic [NUM_CH-1:0] pinGate;

  clkstop_ctrl #(
    .NUM_CH(NUM_CH), .HALF_CYCLES(HALF_CYCLES),
    .SYNC_STAGES(SYNC_STAGES), .PIN_MASK(PIN_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .stopN(stopN), .pdN(pdN),
    .enPin(enPin), .strb(strb), .pinGate(pinGate)
  );

  clkstop_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pinGate(pinGate),
    .cfgEnable(cfgEnable), .cfgStoppable(cfgStoppable),
    .stopDriveZ(stopDriveZ), .pdDriveZ(pdDriveZ),
    .trueOut(trueOut), .compOut(compOut), .trueOe(trueOe), .compOe(compOe)
  );
endmodule

// File: rtl/diff_clk_stop_chk.sv
module diff_clk_stop_chk #(
  parameter int NUM_CH = 4,
  parameter int HALF_CYCLES = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] trueOut,
  input logic [NUM_CH-1:0] compOut,
  input logic [NUM_CH-1:0] trueOe,
  input logic [NUM_CH-1:0] compOe
);
  localparam int LEN_W = $clog2(HALF_CYCLES + 1) + 1;
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(HALF_CYCLES);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic lastT, lastC, lastTo, lastCo;
    logic [LEN_W-1:0] lenT, lenC;

    // Run-length counters for each leg; reset when level or drive changes
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lastT <= 1'b0; lastC <= 1'b0; lastTo <= 1'b0; lastCo <= 1'b0;
        lenT <= '0; lenC <= '0;
      end else begin
        lastT <= trueOut[c]; lastC <= compOut[c];
        lastTo <= trueOe[c]; lastCo <= compOe[c];
        if (trueOut[c] != lastT || trueOe[c] != lastTo) lenT <= LEN_W'(1);
        else if (lenT < LEN_MAX) lenT <= lenT + 1'b1;
        if (compOut[c] != lastC || compOe[c] != lastCo) lenC <= LEN_W'(1);
        else if (lenC < LEN_MAX) lenC <= lenC + 1'b1;
      end
    end

    p_comp_opposite_r11: assert property (@(posedge clk) disable iff (!rstN)
      (trueOe[c] && compOe[c]) |-> (compOut[c] != trueOut[c]));

    p_true_idle_low_r11: assert property (@(posedge clk) disable iff (!rstN)
      !trueOe[c] |-> !trueOut[c]);

    p_comp_idle_low_r11: assert property (@(posedge clk) disable iff (!rstN)
      !compOe[c] |-> !compOut[c]);

    p_comp_needs_true_r4: assert property (@(posedge clk) disable iff (!rstN)
      compOe[c] |-> trueOe[c]);

    p_pd_true_high_r4: assert property (@(posedge clk) disable iff (!rstN)
      (trueOe[c] && !compOe[c]) |-> trueOut[c]);

    p_drive_starts_high_r9: assert property (@(posedge clk) disable iff (!rstN)
      $rose(trueOe[c]) |-> (trueOut[c] && !compOut[c]));

    p_true_no_runt_r9: assert property (@(posedge clk) disable iff (!rstN)
      (trueOe[c] && lastTo && trueOut[c] != lastT) |-> (lenT >= LEN_MAX));

    p_comp_no_runt_r9: assert property (@(posedge clk) disable iff (!rstN)
      (compOe[c] && lastCo && compOut[c] != lastC) |-> (lenC >= LEN_MAX));
  end
endmodule

bind diff_clk_stop diff_clk_stop_chk #(.NUM_CH(NUM_CH), .HALF_CYCLES(HALF_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .trueOut(trueOut), .compOut(compOut),
  .trueOe(trueOe), .compOe(compOe)
);

// File: tb/diff_clk_stop_tb.sv
`timescale 1ns/1ps
module diff_clk_stop_tb;
  localparam int NCH = 4;
  localparam int HALF = 2;
  localparam int PER = 2 * HALF;
  localparam int LAT_MAX = 6 * PER;
  localparam logic [NCH-1:0] PMASK = 4'b1001;
  localparam int RUN = 0, PARK = 1, PDHI = 2, OFF = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopN = 1'b1, pdN = 1'b1;
  logic [NCH-1:0] enPin = '1, cfgEnable = '1, cfgStoppable = '0;
  logic stopDriveZ = 1'b0, pdDriveZ = 1'b0;
  logic [NCH-1:0] trueOut, compOut, trueOe, compOe;

  int total = 0, bad = 0, cyc = 0;
  int runtBad = 0, legBad = 0;
  int got[NCH];

  diff_clk_stop #(.NUM_CH(NCH), .HALF_CYCLES(HALF), .SYNC_STAGES(2), .PIN_MASK(PMASK)) u_dut (
    .clk(clk), .rstN(rstN), .stopN(stopN), .pdN(pdN), .enPin(enPin),
    .cfgEnable(cfgEnable), .cfgStoppable(cfgStoppable),
    .stopDriveZ(stopDriveZ), .pdDriveZ(pdDriveZ),
    .trueOut(trueOut), .compOut(compOut), .trueOe(trueOe), .compOe(compOe)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Watch two output periods and classify each channel
  task automatic classify();
    logic [NCH-1:0] sawT0, sawT1, allTo, allCo, anyTo, anyCo;
    sawT0 = '0; sawT1 = '0; allTo = '1; allCo = '1; anyTo = '0; anyCo = '0;
    repeat (2 * PER) begin
      @(negedge clk);
      sawT0 |= ~trueOut; sawT1 |= trueOut;
      allTo &= trueOe; allCo &= compOe; anyTo |= trueOe; anyCo |= compOe;
    end
    for (int c = 0; c < NCH; c++) begin
      if (!anyTo[c] && !anyCo[c])                                      got[c] = OFF;
      else if (allTo[c] && allCo[c] && sawT0[c] && sawT1[c])           got[c] = RUN;
      else if (allTo[c] && allCo[c] && !sawT0[c] && compOut[c] == 1'b0) got[c] = PARK;
      else if (allTo[c] && !anyCo[c] && !sawT0[c])                     got[c] = PDHI;
      else                                                             got[c] = 9;
    end
  endtask

  // Longest high run of any true leg over n cycles
  task automatic maxHigh(int n, output int mx);
    int run[NCH];
    mx = 0;
    for (int c = 0; c < NCH; c++) run[c] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        run[c] = trueOut[c] ? run[c] + 1 : 0;
        if (run[c] > mx) mx = run[c];
      end
    end
  endtask

  // Independent leg monitor: pulse widths and leg relations
  logic [NCH-1:0] pT, pC, pTo, pCo;
  int lenT[NCH], lenC[NCH];
  always @(negedge clk) begin
    if (!rstN) begin
      pT = '0; pC = '0; pTo = '0; pCo = '0;
      for (int c = 0; c < NCH; c++) begin lenT[c] = 0; lenC[c] = 0; end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (trueOe[c] && compOe[c] && trueOut[c] == compOut[c]) legBad++;
        if (!trueOe[c] && trueOut[c]) legBad++;
        if (!compOe[c] && compOut[c]) legBad++;
        if (trueOe[c] && pTo[c] && trueOut[c] != pT[c] && lenT[c] < HALF) runtBad++;
        if (compOe[c] && pCo[c] && compOut[c] != pC[c] && lenC[c] < HALF) runtBad++;
        if (trueOut[c] != pT[c] || trueOe[c] != pTo[c]) lenT[c] = 1;
        else if (lenT[c] < 1000) lenT[c]++;
        if (compOut[c] != pC[c] || compOe[c] != pCo[c]) lenC[c] = 1;
        else if (lenC[c] < 1000) lenC[c]++;
      end
      pT = trueOut; pC = compOut; pTo = trueOe; pCo = compOe;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=finished", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int mx, lat, hiLen, perLen, togetherBad, f;
    logic resumed;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 reset legs", int'({trueOe, compOe, trueOut, compOut}), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    classify();
    for (int c = 0; c < NCH; c++) chk("R12 running after reset", got[c], RUN);

    // R12: period and high time on channel 0
    while (!(trueOut[0] && !pT[0])) @(negedge clk);
    hiLen = 0; perLen = 0;
    while (trueOut[0]) begin hiLen++; perLen++; @(negedge clk); end
    while (!trueOut[0]) begin perLen++; @(negedge clk); end
    chk("R12 high time", hiLen, HALF);
    chk("R12 period", perLen, PER);

    // R3 R5 R7: stop sweep over drive modes and stoppable masks
    for (int sz = 0; sz < 2; sz++) begin
      for (int m = 0; m < 16; m++) begin
        stopDriveZ = sz[0];
        cfgStoppable = m[NCH-1:0];
        stopN = 1'b0;
        repeat (30) @(negedge clk);
        classify();
        for (int c = 0; c < NCH; c++)
          chk(sz ? "R3 R5 stop three-state" : "R3 R5 stop park", got[c],
              m[c] ? (sz ? OFF : PARK) : RUN);
        stopN = 1'b1;
        f = 0;
        for (int c = NCH - 1; c >= 0; c--) if (m[c]) f = c;
        togetherBad = 0; resumed = 1'b0; lat = 0;
        for (int i = 1; i <= 40; i++) begin
          @(negedge clk);
          for (int c = 0; c < NCH; c++)
            if (m[c] && (trueOut[c] != trueOut[f] || compOut[c] != compOut[f] ||
                         trueOe[c] != trueOe[f])) togetherBad++;
          if (!resumed && (sz ? trueOe[f] : compOut[f])) begin resumed = 1'b1; lat = i; end
        end
        if (m != 0) begin
          chk("R7 resume together", togetherBad, 0);
          chk("R7 resume within six periods", int'(resumed && lat <= LAT_MAX), 1);
        end
        classify();
        for (int c = 0; c < NCH; c++) chk("R7 running after release", got[c], RUN);
      end
    end

    // R1: short stop pulse rejected, long one accepted
    stopDriveZ = 1'b0; cfgStoppable = '1;
    stopN = 1'b0; repeat (3) @(negedge clk); stopN = 1'b1;
    maxHigh(40, mx);
    chk("R1 short stop pulse ignored", mx, HALF);
    stopN = 1'b0; repeat (30) @(negedge clk);
    classify();
    chk("R1 long stop accepted", got[2], PARK);
    stopN = 1'b1; repeat (30) @(negedge clk);

    // R2 R4: power-down priority and drive modes
    stopDriveZ = 1'b1; stopN = 1'b0; repeat (30) @(negedge clk);
    classify();
    chk("R3 stopped three-state before power-down", got[1], OFF);
    pdDriveZ = 1'b0; pdN = 1'b0; repeat (30) @(negedge clk);
    classify();
    for (int c = 0; c < NCH; c++) chk("R2 R4 power-down beats stop", got[c], PDHI);
    pdDriveZ = 1'b1; repeat (12) @(negedge clk);
    classify();
    for (int c = 0; c < NCH; c++) chk("R4 power-down three-state", got[c], OFF);
    pdDriveZ = 1'b0; stopN = 1'b1; repeat (30) @(negedge clk);
    classify();
    for (int c = 0; c < NCH; c++) chk("R2 power-down holds after stop release", got[c], PDHI);
    pdN = 1'b1; repeat (30) @(negedge clk);
    classify();
    for (int c = 0; c < NCH; c++) chk("R2 power-down release", got[c], RUN);
    cfgStoppable = '0; pdN = 1'b0; repeat (30) @(negedge clk);
    classify();
    for (int c = 0; c < NCH; c++) chk("R2 free-running channels power down", got[c], PDHI);
    pdN = 1'b1; repeat (30) @(negedge clk);
    pdN = 1'b0; repeat (3) @(negedge clk); pdN = 1'b1;
    maxHigh(40, mx);
    chk("R2 short power-down glitch ignored", mx, HALF);

    // R6: full enable bit and pin matrix
    for (int e = 0; e < 16; e++) begin
      for (int p = 0; p < 16; p++) begin
        cfgEnable = e[NCH-1:0];
        enPin = p[NCH-1:0];
        repeat (12) @(negedge clk);
        classify();
        for (int c = 0; c < NCH; c++)
          chk("R6 enable matrix", got[c], (e[c] && (!PMASK[c] || p[c])) ? RUN : OFF);
      end
    end

    // R6: disable overrides stop park
    enPin = '1; cfgEnable = 4'b1110; cfgStoppable = '1; stopDriveZ = 1'b0;
    stopN = 1'b0; repeat (30) @(negedge clk);
    classify();
    chk("R6 disabled channel floats while stopped", got[0], OFF);
    chk("R6 enabled channel parks", got[1], PARK);
    stopN = 1'b1; cfgEnable = '1; cfgStoppable = '0; repeat (30) @(negedge clk);

    // R8: enable pin latency
    enPin[0] = 1'b0; lat = 0;
    while (lat < 60 && trueOe[0]) begin @(negedge clk); lat++; end
    chk("R8 pin disable latency", int'(lat <= LAT_MAX), 1);
    enPin[0] = 1'b1; lat = 0;
    while (lat < 60 && !trueOe[0]) begin @(negedge clk); lat++; end
    chk("R8 pin enable latency", int'(lat <= LAT_MAX), 1);
    repeat (10) @(negedge clk);

    chk("R9 runt pulses seen", runtBad, 0);
    chk("R11 leg relation errors", legBad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule